// File: doc/BRIEF.md
# Splittable Six-Input Lookup Table

This block is a six-input lookup table. It holds 64 truth-table bits and 2 mode bits, so 66 configuration bits in all. The truth-table bits are the leaves of a binary tree of 2:1 selectors, and the six logic inputs steer that tree. Stage k of the tree is steered by input k-1, counting stages from 1. Truth-table entry i is the output when the six inputs, read as an unsigned number, equal i and no mode bit is set.

The two mode bits let the table work as two smaller functions. Each mode bit is ORed into one of the two upper inputs, so that input is seen as logic 1 whatever its pin carries. Mode bit 0 forces input 4 and mode bit 1 forces input 5. Nodes from the middle of the tree are brought out as extra outputs: two taps at stage 4 give two 4-input functions, and the two stage-5 nodes give two 5-input functions. The final stage gives the full 6-input result.

The table and the mode bits are held in configuration registers, each loaded by its own write strobe. After reset the mode is 2'b11, which is dual 4-input operation. All results are registered, as they would be in a logic cell that has its output flop in place.

Top module: `flut6_split`

## Requirements
- R1: While `rst` is high, on each rising clock edge the outputs `f6_o`, `f5_o` and `f4_o` are cleared to 0, the table register is loaded with `TABLE_INIT` (default all zero), and the mode register is loaded with `MODE_INIT` (default 2'b11).
- R2: With mode 2'b00, `f6_o` equals table bit `lut_in`, where the 6-bit input is read as an unsigned index.
- R3: Mode bit 0 = 1 forces tree input 4 to 1, so `f6_o` equals table bit (`lut_in` | 6'b010000).
- R4: Mode bit 1 = 1 forces tree input 5 to 1, so `f6_o` equals table bit (`lut_in` | 6'b100000) and matches `f5_o[1]`.
- R5: `f4_o[h]` equals table bit (h*32 + 16 + `lut_in[3:0]`) in every mode. Inputs 4 and 5 have no effect on it.
- R6: `f5_o[h]` equals table bit (h*32 + e), where e is `lut_in[4:0]` with bit 4 ORed with mode bit 0.
- R7: Outputs reflect the `lut_in` value present at the rising edge before the one at which they are sampled. A table or mode write accepted at edge e first affects the outputs registered at edge e+1.
- R8: `tbl_we` loads `tbl_d` only and leaves the mode unchanged. `mode_we` loads `mode_d` only and leaves the table unchanged.
- R9: In mode 2'b11 (the reset default), `f5_o[h]` equals `f4_o[h]` and `f6_o` equals `f4_o[1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_in | input | 6 | Logic inputs; bit k steers tree stage k+1 |
| tbl_we | input | 1 | Load strobe for the truth table |
| tbl_d | input | 64 | Truth-table value; bit i is the result for input index i |
| mode_we | input | 1 | Load strobe for the mode bits |
| mode_d | input | 2 | Mode value; bit 0 forces input 4, bit 1 forces input 5 |
| f6_o | output | 1 | Registered full-tree result |
| f5_o | output | 2 | Registered stage-5 results (lower and upper half) |
| f4_o | output | 2 | Registered stage-4 taps (lower and upper 4-input function) |

## Verification
Each result is due one rising edge after the inputs that produce it. The bench therefore changes `lut_in` and the strobes on the falling edge, waits for one rising edge, and compares all outputs on the following falling edge. A configuration write needs one more edge to show up. The bench checks this by holding the inputs across a write and comparing against the old table right after the write edge and against the new table one edge later. All 64 input patterns are swept in each of the four modes, using several random tables, and the expected values come from indexing the table arithmetically.

// File: rtl/flut_pkg.sv
package flut_pkg;

  // Start of stage s in a flat node vector that holds the leaves first
  // (stage 0) and then each narrower selector stage in turn.
  function automatic int stage_base(input int tbl_w, input int s);
    return 2 * tbl_w - 2 * (tbl_w >> s);
  endfunction

  // Node of the low tap stage that a forced upper input selects.
  // h picks the half of the table.
  function automatic int lo_tap_node(input int n_in, input int lo, input int h);
    int span;
    span = 1 << (n_in - 1 - lo);
    return h * span + (span - 1);
  endfunction

endpackage

// File: rtl/flut_force.sv
module flut_force #(
  parameter int N_IN     = 6,
  parameter int LO_STAGE = 4,
  localparam int N_MODE  = N_IN - LO_STAGE
) (
  input  logic [N_IN-1:0]   raw_in,
  input  logic [N_MODE-1:0] mode,
  output logic [N_IN-1:0]   eff_in
);

  // Inputs below the split point pass straight through.
  assign eff_in[LO_STAGE-1:0] = raw_in[LO_STAGE-1:0];

  // Each upper input is ORed with its own mode bit.
  for (genvar m = 0; m < N_MODE; m++) begin : g_force
    assign eff_in[LO_STAGE+m] = raw_in[LO_STAGE+m] | mode[m];
  end

endmodule

// File: rtl/flut_tree.sv
module flut_tree
  import flut_pkg::*;
#(
  parameter int N_IN     = 6,
  parameter int LO_STAGE = 4,
  localparam int TBL_W   = 1 << N_IN,
  localparam int NODE_W  = 2 * TBL_W - 1
) (
  input  logic [TBL_W-1:0] tbl,
  input  logic [N_IN-1:0]  sel,
  output logic             full_o,
  output logic [1:0]       mid_o,
  output logic [1:0]       lo_o
);

  logic [NODE_W-1:0] node;

  assign node[TBL_W-1:0] = tbl;

  // Stage s halves stage s-1, steered by sel[s-1].
  for (genvar s = 1; s <= N_IN; s++) begin : g_stage
    localparam int W_S   = TBL_W >> s;
    localparam int B_IN  = stage_base(TBL_W, s - 1);
    localparam int B_OUT = stage_base(TBL_W, s);
    for (genvar j = 0; j < W_S; j++) begin : g_node
      assign node[B_OUT+j] = sel[s-1] ? node[B_IN+2*j+1] : node[B_IN+2*j];
    end
  end

  assign full_o = node[stage_base(TBL_W, N_IN)];

  for (genvar h = 0; h < 2; h++) begin : g_tap
    assign mid_o[h] = node[stage_base(TBL_W, N_IN - 1) + h];
    assign lo_o[h]  = node[stage_base(TBL_W, LO_STAGE) + lo_tap_node(N_IN, LO_STAGE, h)];
  end

endmodule

// File: rtl/flut_cfg.sv
module flut_cfg #(
  parameter int N_IN                  = 6,
  parameter int LO_STAGE              = 4,
  localparam int TBL_W                = 1 << N_IN,
  localparam int N_MODE               = N_IN - LO_STAGE,
  parameter logic [TBL_W-1:0]  TABLE_INIT = '0,
  parameter logic [N_MODE-1:0] MODE_INIT  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [TBL_W-1:0]  tbl_d,
  input  logic              mode_we,
  input  logic [N_MODE-1:0] mode_d,
  output logic [TBL_W-1:0]  tbl_q,
  output logic [N_MODE-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= TABLE_INIT;
    end else if (tbl_we) begin
      tbl_q <= tbl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_INIT;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(mode_q)) else $error("mode changed without write"); // R8

endmodule

// File: rtl/flut6_split.sv
module flut6_split
  import flut_pkg::*;
#(
  parameter int N_IN     = 6,
  parameter int LO_STAGE = 4,
  localparam int TBL_W   = 1 << N_IN,
  localparam int N_MODE  = N_IN - LO_STAGE,
  parameter logic [TBL_W-1:0]  TABLE_INIT = '0,
  parameter logic [N_MODE-1:0] MODE_INIT  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   lut_in,
  input  logic              tbl_we,
  input  logic [TBL_W-1:0]  tbl_d,
  input  logic              mode_we,
  input  logic [N_MODE-1:0] mode_d,
  output logic              f6_o,
  output logic [1:0]        f5_o,
  output logic [1:0]        f4_o
);

  logic [TBL_W-1:0]  tbl_q;
  logic [N_MODE-1:0] mode_q;
  logic [N_IN-1:0]   eff_in;
  logic              full_c;
  logic [1:0]        mid_c;
  logic [1:0]        lo_c;

  flut_cfg #(
    .N_IN       (N_IN),
    .LO_STAGE   (LO_STAGE),
    .TABLE_INIT (TABLE_INIT),
    .MODE_INIT  (MODE_INIT)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .tbl_we  (tbl_we),
    .tbl_d   (tbl_d),
    .mode_we (mode_we),
    .mode_d  (mode_d),
    .tbl_q   (tbl_q),
    .mode_q  (mode_q)
  );

  flut_force #(
    .N_IN     (N_IN),
    .LO_STAGE (LO_STAGE)
  ) u_force (
    .raw_in (lut_in),
    .mode   (mode_q),
    .eff_in (eff_in)
  );

  flut_tree #(
    .N_IN     (N_IN),
    .LO_STAGE (LO_STAGE)
  ) u_tree (
    .tbl    (tbl_q),
    .sel    (eff_in),
    .full_o (full_c),
    .mid_o  (mid_c),
    .lo_o   (lo_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f6_o <= 1'b0;
      f5_o <= '0;
      f4_o <= '0;
    end else begin
      f6_o <= full_c;
      f5_o <= mid_c;
      f4_o <= lo_c;
    end
  end

  AST_FORCE_LOW_BIT: assert property (@(posedge clk) disable iff (rst)
    mode_q[0] |-> eff_in[LO_STAGE]) else $error("low forced input not high"); // R3

  AST_FORCE_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
    mode_q[N_MODE-1] |-> eff_in[N_IN-1]) else $error("top forced input not high"); // R4

  AST_TOP_FORCE_TIE: assert property (@(posedge clk) disable iff (rst)
    mode_q[N_MODE-1] |=> (f6_o == f5_o[1])) else $error("full result differs from upper half"); // R4

  AST_DUAL_LO_TIE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '1) |=> ((f5_o == f4_o) && (f6_o == f4_o[1]))) else $error("split taps disagree"); // R9

endmodule

// File: tb/sim_flut6_split.sv
module sim_flut6_split;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  lut_in = '0;
  logic        tbl_we = 1'b0;
  logic [63:0] tbl_d = '0;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_d = '0;
  logic        f6_o;
  logic [1:0]  f5_o;
  logic [1:0]  f4_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flut6_split u0 (
    .clk     (clk),
    .rst     (rst),
    .lut_in  (lut_in),
    .tbl_we  (tbl_we),
    .tbl_d   (tbl_d),
    .mode_we (mode_we),
    .mode_d  (mode_d),
    .f6_o    (f6_o),
    .f5_o    (f5_o),
    .f4_o    (f4_o)
  );

  // Expected {f6, f5[1], f5[0], f4[1], f4[0]}, computed from the requirements.
  function automatic logic [4:0] model(input logic [63:0] t, input logic [1:0] m,
                                       input logic [5:0] x);
    logic [5:0] e;
    e = x | {m, 4'b0000};
    return {t[e], t[{1'b1, e[4:0]}], t[{1'b0, e[4:0]}],
            t[{2'b11, x[3:0]}], t[{2'b01, x[3:0]}]};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] x);
    @(negedge clk);
    lut_in = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_tbl(input logic [63:0] t);
    @(negedge clk);
    tbl_d  = t;
    tbl_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    mode_d  = m;
    mode_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic sweep(input logic [63:0] t, input logic [1:0] m);
    string tag6;
    logic [4:0] e;
    case (m)
      2'b00:   tag6 = "R2";
      2'b01:   tag6 = "R3";
      2'b10:   tag6 = "R4";
      default: tag6 = "R9";
    endcase
    for (int i = 0; i < 64; i++) begin
      apply(6'(i));
      e = model(t, m, 6'(i));
      check(tag6, {4'b0, f6_o}, {4'b0, e[4]});
      check("R6", {3'b0, f5_o}, {3'b0, e[3:2]});
      check("R5", {3'b0, f4_o}, {3'b0, e[1:0]});
      if (m == 2'b11) begin
        check("R9 tie", {f6_o, f5_o, 2'b00}, {f4_o[1], f4_o, 2'b00});
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] t_a;
    logic [63:0] t_b;
    logic [4:0]  e;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: outputs cleared, table zero, mode 2'b11 after reset
    check("R1 outputs", {f6_o, f5_o, f4_o}, 5'b0);
    apply(6'h3f);
    check("R1 table", {f6_o, f5_o, f4_o}, 5'b0);

    // R1/R9: a table-only write keeps the reset mode (dual 4-input)
    t_a = {$urandom, $urandom};
    write_tbl(t_a);
    sweep(t_a, 2'b11);

    // R2, R3, R4 and R5/R6 in every mode, with several tables
    for (int k = 0; k < 3; k++) begin
      t_a = {$urandom, $urandom};
      write_tbl(t_a);
      for (int m = 0; m < 4; m++) begin
        write_mode(2'(m));
        sweep(t_a, 2'(m));
      end
    end

    // R8: a mode write with other data on tbl_d leaves the table alone
    t_b = ~t_a;
    @(negedge clk);
    tbl_d = t_b;
    write_mode(2'b00);
    for (int i = 0; i < 64; i += 7) begin
      apply(6'(i));
      e = model(t_a, 2'b00, 6'(i));
      check("R8 table kept", {f6_o, f5_o, f4_o}, e);
    end

    // R8: a table write with other data on mode_d leaves the mode alone
    @(negedge clk);
    mode_d = 2'b11;
    write_tbl(t_b);
    for (int i = 0; i < 64; i += 5) begin
      apply(6'(i));
      e = model(t_b, 2'b00, 6'(i));
      check("R8 mode kept", {f6_o, f5_o, f4_o}, e);
    end

    // R7: a write at edge e first shows at the output registered at edge e+1
    @(negedge clk);
    lut_in = 6'h2a;
    tbl_d  = t_a;
    tbl_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
    check("R7 old table", {f6_o, f5_o, f4_o}, model(t_b, 2'b00, 6'h2a));
    @(posedge clk);
    @(negedge clk);
    check("R7 new table", {f6_o, f5_o, f4_o}, model(t_a, 2'b00, 6'h2a));

    // R7: the outputs follow the input sampled at the previous edge
    @(negedge clk);
    lut_in = 6'h15;
    @(posedge clk);
    #1;
    lut_in = 6'h2a;
    @(negedge clk);
    check("R7 input timing", {f6_o, f5_o, f4_o}, model(t_a, 2'b00, 6'h15));

    // R1: reset clears the outputs again
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reclear", {f6_o, f5_o, f4_o}, 5'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule